// File: doc/BRIEF.md
# Ready-Node Priority Scheduler

The block holds a small pool of graph nodes whose children have all been computed, so each one is a candidate for processing. A host pushes one candidate per cycle. Each candidate carries a node index, the number of its children that have exactly one fan-out (its releasing children), and the lowest and highest logic levels found among its parents. At any time the block offers the best stored candidate on its pop side. A pop request removes that candidate at the next clock edge.

Candidates are ranked in three steps. A higher releasing-child count wins. When the counts are equal, a candidate wins if the highest level among its parents is below the lowest level among the other candidate's parents. When neither step decides, the smaller node index wins. A linear scan over the occupied slots applies this ordering to select the winner. An occupancy state machine has three states: `S_EMPTY`, `S_SOME` and `S_FULL`. It produces the full and empty flags. A push while full or a pop while empty is ignored and produces a one-cycle error pulse.

State transitions:
- `S_EMPTY` to `S_SOME` (or to `S_FULL` when the capacity is one) on an accepted push.
- `S_SOME` to `S_FULL` on an accepted push alone when one slot is left.
- `S_SOME` to `S_EMPTY` on an accepted pop alone when one entry is left.
- `S_FULL` to `S_SOME` (or to `S_EMPTY` when the capacity is one) on an accepted pop.
- Every other case holds the state.

Top module: `rdy_node_sched`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `pop_valid`=0 and `err`=0.
- R2: Among stored candidates, the one with the largest releasing-child count (`rel`, unsigned) is offered on the pop side, whatever its levels and index.
- R3: With equal `rel`, a candidate whose `lvl_hi` is strictly below the other candidate's `lvl_lo` is offered first, even when its index is larger.
- R4: With equal `rel` and level windows that overlap, the candidate with the smaller node index (unsigned) is offered first.
- R5: The pop-side outputs show the winner in the same cycle that `pop_valid` is high. A pop request removes that entry at the next clock edge, and the entry is never offered again.
- R6: `full` rises after DEPTH accepted pushes with no pops. `empty` returns after every entry has been popped, and `pop_valid` always equals the inverse of `empty`.
- R7: A push while `full` is high stores nothing, so the rejected candidate is never offered. `err` is high for exactly the one cycle after that edge.
- R8: A pop request while `empty` is high removes nothing. `err` is high for exactly the one cycle after that edge.
- R9: An accepted push and an accepted pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push request |
| push_idx | input | IDX_W | Node index of the pushed candidate |
| push_rel | input | REL_W | Releasing-child count of the pushed candidate |
| push_lvl_lo | input | LVL_W | Lowest parent level |
| push_lvl_hi | input | LVL_W | Highest parent level |
| pop_req | input | 1 | Remove the offered candidate |
| pop_valid | output | 1 | A candidate is offered |
| pop_idx | output | IDX_W | Offered node index |
| pop_rel | output | REL_W | Offered releasing-child count |
| pop_lvl_lo | output | LVL_W | Offered lowest parent level |
| pop_lvl_hi | output | LVL_W | Offered highest parent level |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| err | output | 1 | One-cycle pulse after an ignored push or pop |

## Verification
The selection logic is exercised with three kinds of candidate sets:
- Sets where only the releasing-child counts differ, with levels and indices arranged against them. This shows that the count is the first criterion.
- Sets with equal counts and disjoint level windows. Here the level rule must override a smaller index.
- Sets with equal counts and overlapping windows, where only the index can decide.

A full pool is loaded in reverse index order, which separates the index ordering from the slot order. The bench then pushes a winning candidate into the full pool and checks that it never appears. Finally, pushes and pops are issued in the same cycle, both on an empty pool and on a populated one, to show which side is rejected.

// File: rtl/rdy_sched_pkg.sv
`timescale 1ns/1ps
package rdy_sched_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_SOME  = 2'd1,
        S_FULL  = 2'd2
    } occ_state_t;
endpackage

// File: rtl/rdy_free_slot.sv
`timescale 1ns/1ps
module rdy_free_slot #(
    parameter int DEPTH = 8,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]  occupied,
    output logic [SLOT_W-1:0] free_slot
);
    always_comb begin
        free_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                free_slot = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/rdy_best_pick.sv
`timescale 1ns/1ps
module rdy_best_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 8,
    parameter int REL_W = 2,
    parameter int LVL_W = 6,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]  occupied,
    input  logic [IDX_W-1:0]  idx_tab [DEPTH],
    input  logic [REL_W-1:0]  rel_tab [DEPTH],
    input  logic [LVL_W-1:0]  lo_tab  [DEPTH],
    input  logic [LVL_W-1:0]  hi_tab  [DEPTH],
    output logic [SLOT_W-1:0] best_slot
);
    // Three-step preference: releasing count, parent-level window, index.
    function automatic logic beats(
        input logic [IDX_W-1:0] a_idx, input logic [REL_W-1:0] a_rel,
        input logic [LVL_W-1:0] a_lo,  input logic [LVL_W-1:0] a_hi,
        input logic [IDX_W-1:0] b_idx, input logic [REL_W-1:0] b_rel,
        input logic [LVL_W-1:0] b_lo,  input logic [LVL_W-1:0] b_hi);
        logic res;
        if (a_rel != b_rel) begin
            res = (a_rel > b_rel);
        end else if (a_hi < b_lo) begin
            res = 1'b1;
        end else if (b_hi < a_lo) begin
            res = 1'b0;
        end else begin
            res = (a_idx < b_idx);
        end
        return res;
    endfunction

    always_comb begin
        logic have;
        have      = 1'b0;
        best_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (occupied[i]) begin
                if (!have || beats(idx_tab[i], rel_tab[i], lo_tab[i], hi_tab[i],
                                   idx_tab[best_slot], rel_tab[best_slot],
                                   lo_tab[best_slot], hi_tab[best_slot])) begin
                    best_slot = SLOT_W'(i);
                end
                have = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdy_node_sched.sv
`timescale 1ns/1ps
module rdy_node_sched
    import rdy_sched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 8,
    parameter int REL_W = 2,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [REL_W-1:0] push_rel,
    input  logic [LVL_W-1:0] push_lvl_lo,
    input  logic [LVL_W-1:0] push_lvl_hi,
    input  logic             pop_req,
    output logic             pop_valid,
    output logic [IDX_W-1:0] pop_idx,
    output logic [REL_W-1:0] pop_rel,
    output logic [LVL_W-1:0] pop_lvl_lo,
    output logic [LVL_W-1:0] pop_lvl_hi,
    output logic             full,
    output logic             empty,
    output logic             err
);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [DEPTH-1:0]  occ_q;
    logic [IDX_W-1:0]  idx_q [DEPTH];
    logic [REL_W-1:0]  rel_q [DEPTH];
    logic [LVL_W-1:0]  lo_q  [DEPTH];
    logic [LVL_W-1:0]  hi_q  [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;
    occ_state_t        state_q, state_d;

    logic [SLOT_W-1:0] free_slot, best_slot;
    logic              push_ok, pop_ok;

    rdy_free_slot #(.DEPTH(DEPTH)) u_free (
        .occupied  (occ_q),
        .free_slot (free_slot)
    );

    rdy_best_pick #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .REL_W(REL_W), .LVL_W(LVL_W)
    ) u_pick (
        .occupied  (occ_q),
        .idx_tab   (idx_q),
        .rel_tab   (rel_q),
        .lo_tab    (lo_q),
        .hi_tab    (hi_q),
        .best_slot (best_slot)
    );

    assign push_ok = push_valid && !full;
    assign pop_ok  = pop_req && !empty;

    // Slot storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (pop_ok && best_slot == SLOT_W'(i)) begin
                    occ_q[i] <= 1'b0;
                end
                if (push_ok && free_slot == SLOT_W'(i)) begin
                    occ_q[i] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && free_slot == SLOT_W'(i)) begin
                idx_q[i] <= push_idx;
                rel_q[i] <= push_rel;
                lo_q[i]  <= push_lvl_lo;
                hi_q[i]  <= push_lvl_hi;
            end
        end
    end

    // Occupancy state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
            err_q   <= (push_valid && full) || (pop_req && empty);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: begin
                if (push_ok) begin
                    state_d = (DEPTH == 1) ? S_FULL : S_SOME;
                end
            end
            S_SOME: begin
                if (push_ok && !pop_ok && cnt_q == CNT_MAX - CNT_ONE) begin
                    state_d = S_FULL;
                end else if (pop_ok && !push_ok && cnt_q == CNT_ONE) begin
                    state_d = S_EMPTY;
                end
            end
            S_FULL: begin
                if (pop_ok) begin
                    state_d = (DEPTH == 1) ? S_EMPTY : S_SOME;
                end
            end
            default: state_d = S_EMPTY;
        endcase
    end

    // Output logic.
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            S_EMPTY: empty = 1'b1;
            S_SOME:  ;
            S_FULL:  full  = 1'b1;
            default: empty = 1'b1;
        endcase
        pop_valid  = !empty;
        pop_idx    = idx_q[best_slot];
        pop_rel    = rel_q[best_slot];
        pop_lvl_lo = lo_q[best_slot];
        pop_lvl_hi = hi_q[best_slot];
        err        = err_q;
    end
endmodule

// File: rtl/rdy_node_sched_chk.sv
`timescale 1ns/1ps
module rdy_node_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic push_valid,
    input logic pop_req,
    input logic pop_valid,
    input logic full,
    input logic empty,
    input logic err
);
    // R6
    no_full_and_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R6
    valid_tracks_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid == !empty);

    // R7
    push_full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full) |=> err);

    // R7
    push_full_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !pop_req) |=> full);

    // R8
    pop_empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> err);

    // R8
    pop_empty_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_valid) |=> empty);

    // R5
    pop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty && !push_valid) |=> !full);

    // R9
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !full && !pop_req) |=> !empty);
endmodule

bind rdy_node_sched rdy_node_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .full       (full),
    .empty      (empty),
    .err        (err)
);

// File: tb/rdy_node_sched_tb.sv
`timescale 1ns/1ps
module rdy_node_sched_tb;
    localparam int DEPTH = 8;
    localparam int IDX_W = 8;
    localparam int REL_W = 2;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic [IDX_W-1:0] push_idx = '0;
    logic [REL_W-1:0] push_rel = '0;
    logic [LVL_W-1:0] push_lvl_lo = '0;
    logic [LVL_W-1:0] push_lvl_hi = '0;
    logic             pop_req = 1'b0;
    logic             pop_valid;
    logic [IDX_W-1:0] pop_idx;
    logic [REL_W-1:0] pop_rel;
    logic [LVL_W-1:0] pop_lvl_lo;
    logic [LVL_W-1:0] pop_lvl_hi;
    logic             full, empty, err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    rdy_node_sched #(.DEPTH(DEPTH), .IDX_W(IDX_W), .REL_W(REL_W), .LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_idx(push_idx), .push_rel(push_rel),
        .push_lvl_lo(push_lvl_lo), .push_lvl_hi(push_lvl_hi),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_idx(pop_idx),
        .pop_rel(pop_rel), .pop_lvl_lo(pop_lvl_lo), .pop_lvl_hi(pop_lvl_hi),
        .full(full), .empty(empty), .err(err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Inputs change 1 ns after a rising edge; outputs are sampled there too.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int idx, input int rel, input int lo, input int hi);
        push_valid  = 1'b1;
        push_idx    = IDX_W'(idx);
        push_rel    = REL_W'(rel);
        push_lvl_lo = LVL_W'(lo);
        push_lvl_hi = LVL_W'(hi);
        step();
        push_valid  = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input int exp_idx);
        chk({tag, " pop_valid"}, int'(pop_valid), 1);
        chk({tag, " pop_idx"}, int'(pop_idx), exp_idx);
        pop_req = 1'b1;
        step();
        pop_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 pop_valid", int'(pop_valid), 0);
        chk("R1 err", int'(err), 0);
    endtask

    task automatic t_rel_order();
        push(1, 0, 0, 1);
        push(7, 3, 10, 20);
        push(3, 2, 0, 0);
        chk("R2 pop_rel", int'(pop_rel), 3);
        pop_expect("R2 top", 7);
        pop_expect("R2 second", 3);
        pop_expect("R2 third", 1);
        chk("R5 drained empty", int'(empty), 1);
    endtask

    task automatic t_level_window();
        push(2, 1, 6, 9);
        push(5, 1, 3, 4);
        chk("R3 lvl_hi", int'(pop_lvl_hi), 4);
        pop_expect("R3 lower window", 5);
        pop_expect("R3 remaining", 2);
    endtask

    task automatic t_index_tie();
        push(9, 2, 2, 7);
        push(4, 2, 5, 8);
        pop_expect("R4 smaller index", 4);
        pop_expect("R4 remaining", 9);
    endtask

    task automatic fill_reverse();
        for (int k = 17; k >= 10; k--) begin
            push(k, 0, 0, 5);
        end
    endtask

    task automatic t_fill_drain();
        fill_reverse();
        chk("R6 full", int'(full), 1);
        chk("R6 not empty", int'(empty), 0);
        for (int k = 10; k <= 17; k++) begin
            pop_expect("R5 R6 drain", k);
        end
        chk("R6 empty", int'(empty), 1);
        chk("R6 valid low", int'(pop_valid), 0);
    endtask

    task automatic t_overflow();
        fill_reverse();
        push(99, 3, 0, 0);
        chk("R7 err pulse", int'(err), 1);
        chk("R7 still full", int'(full), 1);
        chk("R7 rejected not offered", int'(pop_idx), 10);
        step();
        chk("R7 err one cycle", int'(err), 0);
        for (int k = 10; k <= 17; k++) begin
            pop_expect("R7 drain", k);
        end
        chk("R7 empty after drain", int'(empty), 1);
    endtask

    task automatic t_underflow();
        pop_req = 1'b1;
        step();
        pop_req = 1'b0;
        chk("R8 err pulse", int'(err), 1);
        chk("R8 still empty", int'(empty), 1);
        step();
        chk("R8 err one cycle", int'(err), 0);
    endtask

    task automatic t_simultaneous();
        push(20, 1, 0, 3);
        pop_req = 1'b1;
        push(21, 0, 0, 3);
        pop_req = 1'b0;
        chk("R9 remaining valid", int'(pop_valid), 1);
        chk("R9 err quiet", int'(err), 0);
        pop_expect("R9 pushed survives", 21);
        chk("R9 empty", int'(empty), 1);
        // push accepted while pop on empty rejected
        pop_req = 1'b1;
        push(30, 2, 1, 1);
        pop_req = 1'b0;
        chk("R8 R9 err on empty pop", int'(err), 1);
        pop_expect("R9 push kept", 30);
        chk("R9 empty end", int'(empty), 1);
    endtask

    initial begin
        #1;
        chk("R1 empty in reset", int'(empty), 1);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_rel_order();
        t_level_window();
        t_index_tie();
        t_fill_drain();
        t_overflow();
        t_underflow();
        t_simultaneous();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule